// File: doc/BRIEF.md
# Byte-Packed SPI Data Queues

This block sits between a 32-bit register interface and the serial engine of an SPI controller. Software writes outgoing data as bytes, halfwords or words. Each write is split into bytes, least significant first, and appended to a transmit byte queue. The serial engine drains that queue one byte at a time through a valid/pop stream. Bytes the engine receives are appended to a receive byte queue. Each read of the receive data register removes up to four of them and packs them into one 32-bit word, lowest lane first.

A status word reports the fill of both queues. Fill is counted in whole 32-bit words, with the byte count truncated. The status word also carries two watermark flags, which compare in opposite directions: the transmit flag asks for refill while the queue is low, and the receive flag asks for service once the queue has filled far enough. It also shows receive-empty and transmit-full. Three sticky flags record a transmit write that did not fit, a receive read that found nothing, and a received byte that was lost because the receive queue was full. A flush input empties both queues at once.

Top module: `spi_byte_fifos`

## Requirements
- R1: `wr_size_i` selects the write width: code 0 is 1 byte, code 1 is 2 bytes, code 2 is 4 bytes, and code 3 enqueues nothing. The low bytes of `wr_data_i` are appended with bits 7:0 first.
- R2: `tx_valid_o` is high whenever the transmit queue holds a byte, and `tx_byte_o` is then the oldest byte. A cycle with `tx_pop_i` high removes that byte.
- R3: The transmit queue holds 288 bytes. Free space is counted before any pop in the same cycle. Bytes of a write that do not fit are discarded and set the sticky `tx_overflow_o`; the bytes that fit are kept.
- R4: A read (`rd_en_i`) removes min(4, stored bytes) receive bytes. The oldest byte goes to bits 7:0 and later bytes go to higher lanes. Unfilled lanes are 0. `rd_data_o` shows the word after the read's clock edge and holds it until the next read.
- R5: A read when the receive queue is empty returns 0 and sets the sticky `rx_underflow_o`.
- R6: The receive queue holds 256 bytes. A byte pushed while it is full, counted before any same-cycle read, is discarded and sets the sticky `rx_full_evt_o`.
- R7: `status_o[7:0]` is the transmit byte count divided by 4, and `status_o[15:8]` is the receive byte count divided by 4, both truncated.
- R8: `status_o[26]` is set when the transmit level in words is below `tx_wmark_i`. `status_o[20]` is set when the receive level in words is at or above `rx_wmark_i`.
- R9: `status_o[24]` is set when the receive queue is empty, and `status_o[29]` is set when the transmit queue holds 288 bytes. All other status bits not named in R7 or R8 are 0.
- R10: `flush_i` empties both queues and overrides any write, read, push or pop in the same cycle. The sticky flags and `rd_data_o` keep their values.
- R11: After reset both queues are empty, all sticky flags are clear and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Empty both queues |
| wr_en_i | input | 1 | Transmit data write strobe |
| wr_size_i | input | 2 | Write width code |
| wr_data_i | input | 32 | Transmit write data |
| rd_en_i | input | 1 | Receive data read strobe |
| rd_data_o | output | 32 | Packed receive word of the last read |
| tx_wmark_i | input | 8 | Transmit watermark in words |
| rx_wmark_i | input | 8 | Receive watermark in words |
| status_o | output | 32 | Levels, watermark, empty and full flags |
| tx_valid_o | output | 1 | Transmit stream holds a byte |
| tx_byte_o | output | 8 | Oldest transmit byte |
| tx_pop_i | input | 1 | Serial engine takes the transmit byte |
| rx_push_i | input | 1 | Serial engine delivers a receive byte |
| rx_byte_i | input | 8 | Received byte |
| tx_overflow_o | output | 1 | Sticky: a transmit write lost bytes |
| rx_underflow_o | output | 1 | Sticky: read of an empty receive queue |
| rx_full_evt_o | output | 1 | Sticky: received byte lost to a full queue |

## Verification
Every result is due one clock edge after its stimulus. Queue counts, status bits, the transmit head byte and the sticky flags all change at the edge that takes the write, pop, push, read or flush. `rd_data_o` is loaded at the edge of the read. The bench drives each cycle's inputs one time unit after a rising edge and updates its byte-queue model at the next rising edge. It then compares every output one time unit later, so each check reads the values that the edge has just produced. The watermark inputs act on the status word without a register, so the model reads their current values when it compares.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int unsigned TX_BYTES_DEF = 288;
    localparam int unsigned RX_BYTES_DEF = 256;
    localparam int unsigned LVL_W        = 8;

    localparam int unsigned ST_RX_WM    = 20;
    localparam int unsigned ST_RX_EMPTY = 24;
    localparam int unsigned ST_TX_WM    = 26;
    localparam int unsigned ST_TX_FULL  = 29;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_NONE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [LVL_W-1:0] tx_lvl;
        logic [LVL_W-1:0] rx_lvl;
        logic             rx_empty;
        logic             tx_full;
    } fill_info_t;

    function automatic logic [2:0] acc_bytes(input acc_size_e sz);
        case (sz)
            ACC_BYTE: return 3'd1;
            ACC_HALF: return 3'd2;
            ACC_WORD: return 3'd4;
            default:  return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] make_status(input fill_info_t f,
                                                input logic [LVL_W-1:0] tx_wm,
                                                input logic [LVL_W-1:0] rx_wm);
        logic [31:0] s;
        s               = '0;
        s[7:0]          = f.tx_lvl;
        s[15:8]         = f.rx_lvl;
        s[ST_RX_WM]     = (f.rx_lvl >= rx_wm);
        s[ST_RX_EMPTY]  = f.rx_empty;
        s[ST_TX_WM]     = (f.tx_lvl < tx_wm);
        s[ST_TX_FULL]   = f.tx_full;
        return s;
    endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
    parameter int unsigned DEPTH     = 256,
    parameter int unsigned IN_LANES  = 1,
    parameter int unsigned OUT_LANES = 1,
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned PW = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush_i,
    input  logic [2:0]             push_n_i,
    input  logic [IN_LANES*8-1:0]  push_data_i,
    input  logic [2:0]             pop_n_i,
    output logic [CW-1:0]          count_o,
    output logic [OUT_LANES*8-1:0] head_o
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int unsigned k);
        int unsigned s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    always_ff @(posedge clk) begin
        if (!flush_i) begin
            for (int i = 0; i < IN_LANES; i++) begin
                if (3'(i) < push_n_i) mem[adv(wr_q, i)] <= push_data_i[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= adv(wr_q, int'(push_n_i));
            rd_q  <= adv(rd_q, int'(pop_n_i));
            cnt_q <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
        end
    end

    generate
        for (genvar o = 0; o < OUT_LANES; o++) begin : g_head
            assign head_o[o*8 +: 8] = mem[adv(rd_q, o)];
        end
    endgenerate

    assign count_o = cnt_q;

endmodule

// File: rtl/tx_ingest.sv
module tx_ingest
    import spi_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = TX_BYTES_DEF,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          flush_i,
    input  logic          wr_en_i,
    input  acc_size_e     size_i,
    input  logic [CW-1:0] count_i,
    output logic [2:0]    push_n_o,
    output logic          overflow_o
);

    logic [2:0]    want;
    logic [CW-1:0] free;

    always_comb begin
        want = (wr_en_i && !flush_i) ? acc_bytes(size_i) : 3'd0;
        free = CW'(DEPTH) - count_i;
        if (CW'(want) > free) begin
            push_n_o   = free[2:0];
            overflow_o = 1'b1;
        end else begin
            push_n_o   = want;
            overflow_o = 1'b0;
        end
    end

endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          flush_i,
    input  logic          rd_en_i,
    input  logic [CW-1:0] count_i,
    input  logic [31:0]   head_i,
    output logic [2:0]    pop_n_o,
    output logic [31:0]   word_o,
    output logic          underflow_o
);

    logic [2:0] avail;
    logic       do_rd;

    assign do_rd       = rd_en_i && !flush_i;
    assign avail       = (count_i >= CW'(4)) ? 3'd4 : count_i[2:0];
    assign pop_n_o     = do_rd ? avail : 3'd0;
    assign underflow_o = do_rd && (count_i == '0);

    generate
        for (genvar l = 0; l < 4; l++) begin : g_lane
            assign word_o[l*8 +: 8] = (3'(l) < avail) ? head_i[l*8 +: 8] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/spi_byte_fifos.sv
module spi_byte_fifos
    import spi_fifo_pkg::*;
#(
    parameter int unsigned TX_BYTES = TX_BYTES_DEF,
    parameter int unsigned RX_BYTES = RX_BYTES_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_size_i,
    input  logic [31:0] wr_data_i,
    input  logic        rd_en_i,
    output logic [31:0] rd_data_o,
    input  logic [7:0]  tx_wmark_i,
    input  logic [7:0]  rx_wmark_i,
    output logic [31:0] status_o,
    output logic        tx_valid_o,
    output logic [7:0]  tx_byte_o,
    input  logic        tx_pop_i,
    input  logic        rx_push_i,
    input  logic [7:0]  rx_byte_i,
    output logic        tx_overflow_o,
    output logic        rx_underflow_o,
    output logic        rx_full_evt_o
);

    localparam int unsigned TCW = $clog2(TX_BYTES + 1);
    localparam int unsigned RCW = $clog2(RX_BYTES + 1);

    logic [TCW-1:0] tx_cnt;
    logic [RCW-1:0] rx_cnt;
    logic [2:0]     tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic           tx_ovf_set, rx_und_set, rx_drop;
    logic [31:0]    rx_head, rx_word;
    logic [31:0]    rd_q;
    logic           ovf_q, und_q, full_q;
    fill_info_t     fill;

    tx_ingest #(.DEPTH(TX_BYTES)) u_ingest (
        .flush_i    (flush_i),
        .wr_en_i    (wr_en_i),
        .size_i     (acc_size_e'(wr_size_i)),
        .count_i    (tx_cnt),
        .push_n_o   (tx_push_n),
        .overflow_o (tx_ovf_set)
    );

    assign tx_valid_o = (tx_cnt != '0);
    assign tx_pop_n   = (tx_pop_i && tx_valid_o && !flush_i) ? 3'd1 : 3'd0;

    byte_queue #(.DEPTH(TX_BYTES), .IN_LANES(4), .OUT_LANES(1)) u_txq (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush_i),
        .push_n_i    (tx_push_n),
        .push_data_i (wr_data_i),
        .pop_n_i     (tx_pop_n),
        .count_o     (tx_cnt),
        .head_o      (tx_byte_o)
    );

    assign rx_drop   = rx_push_i && !flush_i && (rx_cnt == RCW'(RX_BYTES));
    assign rx_push_n = (rx_push_i && !flush_i && !rx_drop) ? 3'd1 : 3'd0;

    rx_word_packer #(.DEPTH(RX_BYTES)) u_pack (
        .flush_i     (flush_i),
        .rd_en_i     (rd_en_i),
        .count_i     (rx_cnt),
        .head_i      (rx_head),
        .pop_n_o     (rx_pop_n),
        .word_o      (rx_word),
        .underflow_o (rx_und_set)
    );

    byte_queue #(.DEPTH(RX_BYTES), .IN_LANES(1), .OUT_LANES(4)) u_rxq (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush_i),
        .push_n_i    (rx_push_n),
        .push_data_i (rx_byte_i),
        .pop_n_i     (rx_pop_n),
        .count_o     (rx_cnt),
        .head_o      (rx_head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= '0;
            ovf_q  <= 1'b0;
            und_q  <= 1'b0;
            full_q <= 1'b0;
        end else begin
            if (rd_en_i && !flush_i) rd_q <= rx_word;
            if (tx_ovf_set) ovf_q  <= 1'b1;
            if (rx_und_set) und_q  <= 1'b1;
            if (rx_drop)    full_q <= 1'b1;
        end
    end

    always_comb begin
        fill.tx_lvl   = LVL_W'(tx_cnt >> 2);
        fill.rx_lvl   = LVL_W'(rx_cnt >> 2);
        fill.rx_empty = (rx_cnt == '0);
        fill.tx_full  = (tx_cnt == TCW'(TX_BYTES));
    end

    assign status_o       = make_status(fill, tx_wmark_i, rx_wmark_i);
    assign rd_data_o      = rd_q;
    assign tx_overflow_o  = ovf_q;
    assign rx_underflow_o = und_q;
    assign rx_full_evt_o  = full_q;

endmodule

// File: rtl/spi_byte_fifos_chk.sv
module spi_byte_fifos_chk #(
    parameter int unsigned TX_BYTES = 288,
    parameter int unsigned RX_BYTES = 256
) (
    input logic        clk,
    input logic        rst,
    input logic        flush_i,
    input logic        rd_en_i,
    input logic [31:0] rd_data_o,
    input logic [31:0] status_o,
    input logic        tx_valid_o,
    input logic        rx_push_i,
    input logic        tx_overflow_o,
    input logic        rx_underflow_o,
    input logic        rx_full_evt_o
);

    p_tx_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
        status_o[7:0] <= 8'(TX_BYTES / 4));

    p_rx_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
        status_o[15:8] <= 8'(RX_BYTES / 4));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        tx_overflow_o |=> tx_overflow_o);

    p_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !flush_i && status_o[24]) |=> (rx_underflow_o && rd_data_o == 32'h0));

    p_rx_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_push_i && !flush_i && !rd_en_i && status_o[15:8] == 8'(RX_BYTES / 4))
            |=> (rx_full_evt_o && status_o[15:8] == 8'(RX_BYTES / 4)));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (status_o[24] && !tx_valid_o && status_o[7:0] == 8'h0));

    p_tx_full_valid_r9: assert property (@(posedge clk) disable iff (rst)
        status_o[29] |-> tx_valid_o);

endmodule

bind spi_byte_fifos spi_byte_fifos_chk #(.TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .flush_i        (flush_i),
    .rd_en_i        (rd_en_i),
    .rd_data_o      (rd_data_o),
    .status_o       (status_o),
    .tx_valid_o     (tx_valid_o),
    .rx_push_i      (rx_push_i),
    .tx_overflow_o  (tx_overflow_o),
    .rx_underflow_o (rx_underflow_o),
    .rx_full_evt_o  (rx_full_evt_o)
);

// File: tb/sim_spi_byte_fifos.sv
module sim_spi_byte_fifos;

    localparam int CLK_PERIOD = 10;
    localparam int TXD = 288;
    localparam int RXD = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic        tx_pop_i = 1'b0, rx_push_i = 1'b0;
    logic [1:0]  wr_size_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [7:0]  rx_byte_i = '0, tx_wmark_i = '0, rx_wmark_i = '0;
    logic [31:0] rd_data_o, status_o;
    logic        tx_valid_o, tx_overflow_o, rx_underflow_o, rx_full_evt_o;
    logic [7:0]  tx_byte_o;

    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [31:0] m_rd;
    bit          m_ovf, m_und, m_full;
    int          total = 0, bad = 0, cyc = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_byte_fifos u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        int tw, rw;
        tw = txq.size() / 4;
        rw = rxq.size() / 4;
        s = '0;
        s[7:0]  = 8'(tw);
        s[15:8] = 8'(rw);
        s[20]   = (rw >= int'(rx_wmark_i));
        s[24]   = (rxq.size() == 0);
        s[26]   = (tw < int'(tx_wmark_i));
        s[29]   = (txq.size() == TXD);
        return s;
    endfunction

    task automatic compare_all();
        chk("R7 R8 R9 status", status_o, exp_status());
        chk("R4 R5 rd_data", rd_data_o, m_rd);
        chk("R3 tx_overflow", 32'(tx_overflow_o), 32'(m_ovf));
        chk("R5 rx_underflow", 32'(rx_underflow_o), 32'(m_und));
        chk("R6 rx_full_evt", 32'(rx_full_evt_o), 32'(m_full));
        chk("R2 tx_valid", 32'(tx_valid_o), 32'(txq.size() != 0));
        if (txq.size() != 0) chk("R1 R2 tx_byte", 32'(tx_byte_o), 32'(txq[0]));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        flush_i = 0; wr_en_i = 0; rd_en_i = 0; tx_pop_i = 0; rx_push_i = 0;
        @(posedge clk); @(posedge clk);
        #1 rst = 1'b0;
        txq.delete(); rxq.delete();
        m_rd = '0; m_ovf = 0; m_und = 0; m_full = 0;
        compare_all();
        chk("R11 reset empty", {status_o[24], tx_valid_o}, 32'h2);
    endtask

    task automatic cyc1(input bit wr, input logic [1:0] sz, input logic [31:0] d,
                        input bit rd, input bit tp, input bit rp, input logic [7:0] rb,
                        input bit fl);
        int tn, rn, n, fr, k;
        logic [31:0] w;
        flush_i = fl; wr_en_i = wr; wr_size_i = sz; wr_data_i = d;
        rd_en_i = rd; tx_pop_i = tp; rx_push_i = rp; rx_byte_i = rb;
        @(posedge clk);
        tn = txq.size(); rn = rxq.size();
        if (fl) begin
            txq.delete(); rxq.delete();
        end else begin
            if (tp && tn > 0) void'(txq.pop_front());
            if (wr) begin
                n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
                fr = TXD - tn;
                for (int i = 0; i < n; i++) if (i < fr) txq.push_back(d[i*8 +: 8]);
                if (n > fr) m_ovf = 1;
            end
            if (rd) begin
                if (rn == 0) begin
                    m_und = 1; m_rd = '0;
                end else begin
                    k = (rn < 4) ? rn : 4;
                    w = '0;
                    for (int j = 0; j < k; j++) w[j*8 +: 8] = rxq.pop_front();
                    m_rd = w;
                end
            end
            if (rp) begin
                if (rn == RXD) m_full = 1;
                else rxq.push_back(rb);
            end
        end
        #1;
        flush_i = 0; wr_en_i = 0; rd_en_i = 0; tx_pop_i = 0; rx_push_i = 0;
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd2024));
        m_rd = '0;
        tx_wmark_i = 8'd2; rx_wmark_i = 8'd1;
        do_reset();

        // R1: widths and byte order, code 3 writes nothing
        cyc1(1, 2'd0, 32'hFFFF_FFA1, 0, 0, 0, 0, 0);
        cyc1(1, 2'd1, 32'hFFFF_B2C3, 0, 0, 0, 0, 0);
        cyc1(1, 2'd3, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
        cyc1(1, 2'd2, 32'h1122_3344, 0, 0, 0, 0, 0);
        chk("R1 seven bytes queued", 32'(txq.size()), 32'd7);
        for (int i = 0; i < 7; i++) cyc1(0, 0, 0, 0, 1, 0, 0, 0);

        // R3/R9: fill to 288, then overflow
        for (int i = 0; i < 72; i++) cyc1(1, 2'd2, 32'hA000_0000 + i, 0, 0, 0, 0, 0);
        chk("R9 tx full bit", 32'(status_o[29]), 32'd1);
        cyc1(1, 2'd0, 32'h55, 0, 1, 0, 0, 0);
        chk("R3 overflow on full", 32'(tx_overflow_o), 32'd1);
        do_reset();
        for (int i = 0; i < 71; i++) cyc1(1, 2'd2, 32'hB000_0000 + i, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc1(1, 2'd0, 32'hC0 + i, 0, 0, 0, 0, 0);
        cyc1(1, 2'd2, 32'hD4D3_D2D1, 0, 0, 0, 0, 0);
        chk("R3 partial write kept one", 32'(txq.size()), 32'd288);
        for (int i = 0; i < 300; i++) cyc1(0, 0, 0, 0, 1, 0, 0, 0);

        // R4/R5: packing and underflow
        do_reset();
        for (int i = 0; i < 5; i++) cyc1(0, 0, 0, 0, 0, 1, 8'h10 + 8'(i), 0);
        cyc1(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 four lanes", rd_data_o, 32'h1312_1110);
        cyc1(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 one lane zero filled", rd_data_o, 32'h0000_0014);
        cyc1(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 empty read", {rd_data_o[30:0], rx_underflow_o}, 32'h1);

        // R6/R8: fill RX and drop
        do_reset();
        rx_wmark_i = 8'd64;
        for (int i = 0; i < 257; i++) cyc1(0, 0, 0, 0, 0, 1, 8'(i * 7), 0);
        chk("R6 full drop flag", 32'(rx_full_evt_o), 32'd1);
        chk("R8 rx watermark at 64", 32'(status_o[20]), 32'd1);

        // R10: flush overrides traffic
        cyc1(1, 2'd2, 32'h1234_5678, 1, 1, 1, 8'h99, 1);
        chk("R10 flushed", {status_o[24], tx_valid_o, rx_full_evt_o}, 32'h5);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) begin
                tx_wmark_i = 8'($urandom_range(0, 80));
                rx_wmark_i = 8'($urandom_range(0, 70));
            end
            if (i % 2000 == 1999) do_reset();
            else cyc1($urandom_range(0, 99) < 45, 2'($urandom()), $urandom(),
                      $urandom_range(0, 99) < 15, $urandom_range(0, 99) < 30,
                      $urandom_range(0, 99) < 55, 8'($urandom()),
                      $urandom_range(0, 999) < 3);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule